// File: doc/BRIEF.md
# One-Bit Serial Control Processor Core

This block is the execution core of a one-bit controller. Every rising edge of the design clock it takes one 4-bit instruction. It updates a one-bit result register, a carry flag and two enable latches. Operands are read from a single bidirectional data bit, and results are written back to that same bit. The datapath supports add and subtract with carry, NAND, OR and XOR. The result register can be stored in true or inverted form. An instruction can ask for the following slot to be suppressed when the result register holds zero.

The program counter, program memory, I/O address decoding and any call stack sit outside the core. The core reports what it executed through one-cycle registered strobes: a write, a jump, a return, one strobe for each of the two no-op codes, and a skipped slot. External sequencing logic acts on these strobes. The input-enable latch gates every operand read. The output-enable latch gates every store.

Top module: `bitcpu_core`

## Requirements
- R1: A synchronous active-low reset clears the result register, the carry, both enable latches and any pending skip. During reset and in the first cycle after it, every strobe output is 0.
- R2: LD (opcode 0x1) loads the result register with the data bit ANDed with the input-enable latch. This masking applies to every operand read by LD, ADD, SUB, NAND, OR and XOR.
- R3: ADD (0x2) adds the result register, the masked data bit and the carry. The sum bit goes to the result register and the carry-out goes to the carry.
- R4: SUB (0x3) works like ADD but uses the inverted masked data bit.
- R5: ONE (0x4) sets the result register to 1 and clears the carry.
- R6: NAND (0x5), OR (0x6) and XOR (0x7) combine the result register with the masked data bit and write the result back to the result register. The carry is left unchanged.
- R7: When the output-enable latch is 1, STO (0x8) and STOC (0x9) raise the write strobe for one cycle. During that same cycle the core drives the data bit with the result register (STO) or its inverse (STOC).
- R8: When the output-enable latch is 0, STO and STOC raise no write strobe and leave the data bit undriven.
- R9: Opcodes 0xA and 0xB load the input-enable and output-enable latch, respectively, from the raw unmasked data bit. The result register and the carry are left unchanged.
- R10: JMP (0xC), RTN (0xD), the low no-op (0x0) and the high no-op (0xF) each raise their own strobe for one cycle. None of them changes the result register, the carry or either latch.
- R11: SKZ (0xE) executed with the result register at 0 turns the next instruction into a slot with no effect and no strobe of its own. The skip strobe is raised for one cycle instead. When the result register is 1, SKZ suppresses nothing.
- R12: An SKZ that is itself suppressed does not arm a further skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 4 | Instruction opcode for this cycle |
| data_io | inout | 1 | Shared operand / store data bit |
| wr_stb_o | output | 1 | Store executed (write strobe) |
| carry_o | output | 1 | Carry flag |
| in_en_o | output | 1 | Input-enable latch |
| out_en_o | output | 1 | Output-enable latch |
| jump_stb_o | output | 1 | Jump executed |
| ret_stb_o | output | 1 | Return executed |
| nop_lo_stb_o | output | 1 | Low no-op (0x0) executed |
| nop_hi_stb_o | output | 1 | High no-op (0xF) executed |
| skip_stb_o | output | 1 | Previous slot was suppressed |

## Verification
The assertions assume a known opcode is present at every rising edge once reset is released. They also assume that nothing outside the core fights the data bit in a cycle where the core is driving it. The stimulus honours this. The bench releases the bus in the cycle after every store opcode, and it places only an instruction that reads no operand in that cycle. Reset is held low from time zero for several edges, so that every state and history check starts from cleared registers.

// File: rtl/bitcpu_pkg.sv
package bitcpu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOPLO = 4'h0,
        OP_LD    = 4'h1,
        OP_ADD   = 4'h2,
        OP_SUB   = 4'h3,
        OP_ONE   = 4'h4,
        OP_NAND  = 4'h5,
        OP_OR    = 4'h6,
        OP_XOR   = 4'h7,
        OP_STO   = 4'h8,
        OP_STOC  = 4'h9,
        OP_LDIE  = 4'hA,
        OP_LDOE  = 4'hB,
        OP_JMP   = 4'hC,
        OP_RTN   = 4'hD,
        OP_SKZ   = 4'hE,
        OP_NOPHI = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        FN_HOLD, FN_LOAD, FN_ADD, FN_SUB, FN_ONE, FN_NAND, FN_OR, FN_XOR
    } alu_fn_e;

    typedef struct packed {
        alu_fn_e fn;
        logic    store;
        logic    store_inv;
        logic    load_ie;
        logic    load_oe;
        logic    skz;
        logic    jump;
        logic    ret;
        logic    nop_lo;
        logic    nop_hi;
    } ctrl_t;

    typedef struct packed {
        logic rr;
        logic carry;
    } acc_t;

    typedef struct packed {
        logic wr;
        logic jump;
        logic ret;
        logic nop_lo;
        logic nop_hi;
        logic skip;
    } pulse_t;

    function automatic acc_t alu_eval(alu_fn_e fn, acc_t a, logic d);
        acc_t       r;
        logic [1:0] s;
        r = a;
        s = 2'b00;
        case (fn)
            FN_LOAD: r.rr = d;
            FN_ADD: begin
                s = {1'b0, a.rr} + {1'b0, d} + {1'b0, a.carry};
                r = {s[0], s[1]};
            end
            FN_SUB: begin
                s = {1'b0, a.rr} + {1'b0, ~d} + {1'b0, a.carry};
                r = {s[0], s[1]};
            end
            FN_ONE:  r = '{rr: 1'b1, carry: 1'b0};
            FN_NAND: r.rr = ~(a.rr & d);
            FN_OR:   r.rr = a.rr | d;
            FN_XOR:  r.rr = a.rr ^ d;
            default: r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bitcpu_decode.sv
module bitcpu_decode
    import bitcpu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic            squash_i,
    output ctrl_t           ctrl_o
);
    op_e op;
    assign op = op_e'(op_i);

    always_comb begin
        ctrl_o = '0;
        if (!squash_i) begin
            case (op)
                OP_LD:    ctrl_o.fn = FN_LOAD;
                OP_ADD:   ctrl_o.fn = FN_ADD;
                OP_SUB:   ctrl_o.fn = FN_SUB;
                OP_ONE:   ctrl_o.fn = FN_ONE;
                OP_NAND:  ctrl_o.fn = FN_NAND;
                OP_OR:    ctrl_o.fn = FN_OR;
                OP_XOR:   ctrl_o.fn = FN_XOR;
                OP_STO:   ctrl_o.store = 1'b1;
                OP_STOC: begin
                    ctrl_o.store     = 1'b1;
                    ctrl_o.store_inv = 1'b1;
                end
                OP_LDIE:  ctrl_o.load_ie = 1'b1;
                OP_LDOE:  ctrl_o.load_oe = 1'b1;
                OP_JMP:   ctrl_o.jump    = 1'b1;
                OP_RTN:   ctrl_o.ret     = 1'b1;
                OP_SKZ:   ctrl_o.skz     = 1'b1;
                OP_NOPLO: ctrl_o.nop_lo  = 1'b1;
                OP_NOPHI: ctrl_o.nop_hi  = 1'b1;
                default:  ctrl_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/bitcpu_alu.sv
module bitcpu_alu
    import bitcpu_pkg::*;
(
    input  alu_fn_e fn_i,
    input  acc_t    acc_i,
    input  logic    data_i,
    input  logic    in_en_i,
    output acc_t    acc_o
);
    logic operand;
    assign operand = data_i & in_en_i;
    assign acc_o   = alu_eval(fn_i, acc_i, operand);
endmodule

// File: rtl/bitcpu_regs.sv
module bitcpu_regs
    import bitcpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl_i,
    input  logic  squash_i,
    input  acc_t  acc_nxt_i,
    input  logic  data_i,
    output acc_t  acc_o,
    output logic  in_en_o,
    output logic  out_en_o,
    output logic  pend_o,
    output logic  drv_en_o,
    output logic  drv_val_o,
    output pulse_t pulse_o
);
    logic store_go;
    assign store_go = ctrl_i.store & out_en_o;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o     <= '0;
            in_en_o   <= 1'b0;
            out_en_o  <= 1'b0;
            pend_o    <= 1'b0;
            drv_en_o  <= 1'b0;
            drv_val_o <= 1'b0;
            pulse_o   <= '0;
        end else begin
            acc_o     <= acc_nxt_i;
            if (ctrl_i.load_ie) in_en_o  <= data_i;
            if (ctrl_i.load_oe) out_en_o <= data_i;
            pend_o    <= ctrl_i.skz & ~acc_o.rr;
            drv_en_o  <= store_go;
            drv_val_o <= acc_o.rr ^ ctrl_i.store_inv;
            pulse_o   <= '{wr:     store_go,
                           jump:   ctrl_i.jump,
                           ret:    ctrl_i.ret,
                           nop_lo: ctrl_i.nop_lo,
                           nop_hi: ctrl_i.nop_hi,
                           skip:   squash_i};
        end
    end
endmodule

// File: rtl/bitcpu_core.sv
module bitcpu_core
    import bitcpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] instr_i,
    inout  wire        data_io,
    output logic       wr_stb_o,
    output logic       carry_o,
    output logic       in_en_o,
    output logic       out_en_o,
    output logic       jump_stb_o,
    output logic       ret_stb_o,
    output logic       nop_lo_stb_o,
    output logic       nop_hi_stb_o,
    output logic       skip_stb_o
);
    ctrl_t  ctrl;
    acc_t   acc_q;
    acc_t   acc_nxt;
    pulse_t pulse;
    logic   skip_pend;
    logic   drv_en;
    logic   drv_val;
    logic   rr_q;

    bitcpu_decode u_decode (
        .op_i     (instr_i),
        .squash_i (skip_pend),
        .ctrl_o   (ctrl)
    );

    bitcpu_alu u_alu (
        .fn_i    (ctrl.fn),
        .acc_i   (acc_q),
        .data_i  (data_io),
        .in_en_i (in_en_o),
        .acc_o   (acc_nxt)
    );

    bitcpu_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_i    (ctrl),
        .squash_i  (skip_pend),
        .acc_nxt_i (acc_nxt),
        .data_i    (data_io),
        .acc_o     (acc_q),
        .in_en_o   (in_en_o),
        .out_en_o  (out_en_o),
        .pend_o    (skip_pend),
        .drv_en_o  (drv_en),
        .drv_val_o (drv_val),
        .pulse_o   (pulse)
    );

    assign data_io      = drv_en ? drv_val : 1'bz;
    assign rr_q         = acc_q.rr;
    assign carry_o      = acc_q.carry;
    assign wr_stb_o     = pulse.wr;
    assign jump_stb_o   = pulse.jump;
    assign ret_stb_o    = pulse.ret;
    assign nop_lo_stb_o = pulse.nop_lo;
    assign nop_hi_stb_o = pulse.nop_hi;
    assign skip_stb_o   = pulse.skip;
endmodule

// File: rtl/bitcpu_core_chk.sv
module bitcpu_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] instr,
    input logic       pend,
    input logic       rr,
    input logic       carry,
    input logic       ien,
    input logic       oen,
    input logic       drv_en,
    input logic       wr,
    input logic       jmp,
    input logic       ret,
    input logic       nlo,
    input logic       nhi,
    input logic       skip
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!rr && !carry && !ien && !oen && !pend &&
                    !wr && !jmp && !ret && !nlo && !nhi && !skip)); // R1

    AST_ONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (instr == 4'h4 && !pend) |=> (rr && !carry)); // R5

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> drv_en); // R7

    AST_NO_WRITE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!oen && (instr == 4'h8 || instr == 4'h9)) |=> (!wr && !drv_en)); // R8

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr, jmp, ret, nlo, nhi, skip})); // R10

    AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((instr == 4'h0 || instr == 4'hF || instr == 4'hC || instr == 4'hD) && !pend)
        |=> ($stable(rr) && $stable(carry) && $stable(ien) && $stable(oen))); // R10

    AST_SKIP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> (skip && !pend && $stable(rr) && $stable(carry) &&
                  $stable(ien) && $stable(oen))); // R11
endmodule

bind bitcpu_core bitcpu_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .instr  (instr_i),
    .pend   (skip_pend),
    .rr     (rr_q),
    .carry  (carry_o),
    .ien    (in_en_o),
    .oen    (out_en_o),
    .drv_en (drv_en),
    .wr     (wr_stb_o),
    .jmp    (jump_stb_o),
    .ret    (ret_stb_o),
    .nlo    (nop_lo_stb_o),
    .nhi    (nop_hi_stb_o),
    .skip   (skip_stb_o)
);

// File: tb/bitcpu_core_tb.sv
`timescale 1ns/1ps
module bitcpu_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] instr = 4'h0;
    logic       tb_drv = 1'b1;
    logic       tb_val = 1'b0;
    wire        data_bus;
    logic wr, car, ie, oe, jmp, ret, nlo, nhi, skp;

    assign data_bus = tb_drv ? tb_val : 1'bz;
    always #2.5 clk = ~clk;

    bitcpu_core u_dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .data_io(data_bus),
        .wr_stb_o(wr), .carry_o(car), .in_en_o(ie), .out_en_o(oe),
        .jump_stb_o(jmp), .ret_stb_o(ret), .nop_lo_stb_o(nlo),
        .nop_hi_stb_o(nhi), .skip_stb_o(skp)
    );

    typedef struct {
        logic  wr, jmp, ret, nlo, nhi, skp, car, ie, oe;
        logic  bus_chk, bus_val;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    logic m_rr = 0, m_c = 0, m_ie = 0, m_oe = 0, m_pend = 0, prev_store = 0;

    task automatic exec(input logic [3:0] op, input logic d, input string req);
        exp_t e;
        logic dm;
        logic [1:0] s;
        instr  = op;
        tb_val = d;
        tb_drv = !prev_store;
        @(posedge clk);
        e = '{wr:0, jmp:0, ret:0, nlo:0, nhi:0, skp:0, car:0, ie:0, oe:0,
              bus_chk:0, bus_val:0, req:req};
        dm = d & m_ie;
        if (m_pend) begin
            e.skp  = 1;
            m_pend = 0;
        end else begin
            case (op)
                4'h0: e.nlo = 1;
                4'h1: m_rr = dm;
                4'h2: begin s = m_rr + dm + m_c; m_rr = s[0]; m_c = s[1]; end
                4'h3: begin s = m_rr + !dm + m_c; m_rr = s[0]; m_c = s[1]; end
                4'h4: begin m_rr = 1; m_c = 0; end
                4'h5: m_rr = !(m_rr & dm);
                4'h6: m_rr = m_rr | dm;
                4'h7: m_rr = m_rr ^ dm;
                4'h8, 4'h9: if (m_oe) begin
                    e.wr = 1; e.bus_chk = 1;
                    e.bus_val = (op == 4'h9) ? !m_rr : m_rr;
                end
                4'hA: m_ie = d;
                4'hB: m_oe = d;
                4'hC: e.jmp = 1;
                4'hD: e.ret = 1;
                4'hE: m_pend = !m_rr;
                default: e.nhi = 1;
            endcase
        end
        prev_store = (op == 4'h8 || op == 4'h9);
        e.car = m_c; e.ie = m_ie; e.oe = m_oe;
        q.push_back(e);
        #1;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                n_chk++;
                if ({wr, jmp, ret, nlo, nhi, skp, car, ie, oe} !==
                    {e.wr, e.jmp, e.ret, e.nlo, e.nhi, e.skp, e.car, e.ie, e.oe} ||
                    (e.bus_chk && data_bus !== e.bus_val)) begin
                    n_bad++;
                    $display("FAIL %s: got wr%b j%b r%b nl%b nh%b sk%b c%b ie%b oe%b bus%b, exp wr%b j%b r%b nl%b nh%b sk%b c%b ie%b oe%b bus%b",
                        e.req, wr, jmp, ret, nlo, nhi, skp, car, ie, oe, data_bus,
                        e.wr, e.jmp, e.ret, e.nlo, e.nhi, e.skp, e.car, e.ie, e.oe, e.bus_val);
                end
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin : stim
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++; // R1: reset state of every output
        if ({wr, car, ie, oe, jmp, ret, nlo, nhi, skp} !== 9'b0) begin
            n_bad++;
            $display("FAIL R1: got %b expected 000000000",
                     {wr, car, ie, oe, jmp, ret, nlo, nhi, skp});
        end
        @(posedge clk); #1;
        exec(4'hB, 1, "R9");   // enable output
        exec(4'h8, 0, "R1");   // RR cleared by reset
        exec(4'h0, 0, "R10");
        exec(4'h1, 1, "R2");   // IEN=0 masks operand
        exec(4'hA, 1, "R9");
        exec(4'h1, 1, "R2");
        exec(4'h8, 0, "R7");
        exec(4'hF, 0, "R10");
        exec(4'h2, 1, "R3");
        exec(4'h2, 1, "R3");
        exec(4'h2, 0, "R3");
        exec(4'h3, 0, "R4");
        exec(4'h3, 1, "R4");
        exec(4'h4, 0, "R5");
        exec(4'h5, 1, "R6");
        exec(4'h6, 1, "R6");
        exec(4'h7, 1, "R6");
        exec(4'h9, 0, "R7");
        exec(4'h0, 0, "R10");
        exec(4'hE, 0, "R11");  // RR=0: arm
        exec(4'h1, 1, "R11");  // suppressed
        exec(4'h8, 0, "R11");  // RR still 0
        exec(4'h0, 0, "R10");
        exec(4'h4, 0, "R5");
        exec(4'hE, 0, "R11");  // RR=1: no skip
        exec(4'h1, 0, "R11");
        exec(4'hE, 0, "R12");  // RR=0: arm
        exec(4'hE, 0, "R12");  // suppressed, no re-arm
        exec(4'h1, 1, "R12");  // executes
        exec(4'h8, 0, "R12");
        exec(4'h0, 0, "R10");
        exec(4'hC, 0, "R10");
        exec(4'hD, 0, "R10");
        exec(4'hB, 0, "R9");
        exec(4'h8, 0, "R8");
        exec(4'h0, 0, "R8");
        exec(4'hB, 1, "R9");
        exec(4'hA, 0, "R9");
        exec(4'h1, 1, "R2");
        exec(4'h8, 0, "R2");
        exec(4'h0, 0, "R10");
        exec(4'hA, 1, "R9");
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            if (op == 4'h8 || op == 4'h9 || op == 4'hB) op = 4'h7;
            exec(op, 1'($urandom_range(0, 1)), "R6");
            if (i % 8 == 7) begin
                exec(4'h8, 0, "R7");
                exec(4'h0, 0, "R10");
            end
        end
        exec(4'h0, 0, "R10");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule